// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

The block is one DMA channel that copies a run of data units from a source address to a destination address. Software loads a source address, a destination address, a byte count and a mode word through a small register port. A start bit in the mode word launches the run. Each unit is moved in two phases on a simple internal bus: a read from the source, with the data held inside the block, then a write of that data to the destination. After each phase the address involved either stays fixed or advances by the unit size, and the byte count drops by the unit size after each write.

Completion, bus faults and bad configurations are recorded in sticky status flags. A set sequence-end, bus-fault or bad-configuration flag blocks every later start until software clears it by writing a 1 to it. An interrupt output combines the flags with per-flag enables held in the mode word.

Register map, selected by `reg_sel`:
- 0: source address
- 1: destination address
- 2: byte count
- 3: mode
- 4: status

Any other select reads as zero.

Mode word bits:
- bit 0: start. It is acted on only when written and always reads 0.
- bits 2:1: unit size code. 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, and 3 is reserved.
- bit 3: source advances.
- bit 4: destination advances.
- bit 5: one-unit-per-start mode. When this bit is 0 the channel runs continuously.
- bits 11:8: interrupt enables, in the same order as status bits 3:0.

Status bits:
- bit 0: unit done
- bit 1: sequence end
- bit 2: bus fault
- bit 3: bad configuration
- bit 4: busy, read-only

Top module: `dma_chan`

## Requirements
- R1: After reset all five registers read 0 and `irq` is 0.
- R2: While the channel is idle, writes to selects 0 to 3 update the register, and the mode word reads back with bit 0 as 0. While the channel is busy, writes to selects 0 to 3 are ignored.
- R3: Each unit is moved in two steps. First a read request goes out with `bus_we`=0, `bus_addr` equal to the source address and `bus_size` equal to the size code. Then a write request goes out with `bus_we`=1 to the destination address, carrying the read data unchanged. A request holds its address and direction until `bus_ack` arrives.
- R4: The source address advances by the unit size after a faultless read when bit 3 is set, and stays fixed otherwise. The destination address advances by the unit size after a faultless write when bit 4 is set, and stays fixed otherwise. The count drops by the unit size after each faultless write and changes at no other time except a register write.
- R5: In continuous mode the channel moves count/size units and then goes idle. In one-unit-per-start mode each start moves exactly one unit.
- R6: Sequence end (status bit 1) sets when a write brings the count to 0. It is cleared only by writing a 1 to it; writing 0 leaves it set.
- R7: A `bus_err` on an acknowledged access sets bus fault (status bit 2), ends the run, and applies no update for that phase. The flag is cleared only by writing a 1 to it.
- R8: Unit done (status bit 0) sets after every faultless write. Only reset clears it; writing to it has no effect.
- R9: A start is refused and bad configuration (status bit 3) is set, with no bus request, in any of these cases: the size code is 3; the count is 0; the count is not a multiple of the unit size; or continuous mode is selected with neither address advancing. The flag clears by writing a 1 to it.
- R10: While status bit 1, 2 or 3 is set, a start is ignored and no bus request is made.
- R11: `irq` is 1 exactly when some status bit n (n = 0 to 3) and mode bit 8+n are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_sel` |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 32 | Bus address |
| bus_size | output | 2 | Unit size code of the access |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access accepted this cycle |
| bus_err | input | 1 | Access faulted, valid with `bus_ack` |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. A start therefore raises `bus_req` in the following cycle, and `irq` and the read-back follow one edge after the write. Each flag and address update lands on the edge that samples the matching `bus_ack`. The bench drives inputs on the falling edge and reads registers shortly after a falling edge. After a start it polls the busy bit until it drops and only then compares addresses, count, flags and the logged bus traffic. Variable wait states between request and acknowledge test that the results do not depend on bus latency.

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  output logic              irq
);
  typedef enum logic [1:0] {IDLE, RD, WR} st_t;
  st_t st;

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hold_q;
  logic [1:0]        sz_q;
  logic              sinc_q, dinc_q, steal_q;
  logic [3:0]        ien_q;
  logic              tc_q, asc_q, te_q, inv_q;

  wire busy    = st != IDLE;
  wire blocked = asc_q | te_q | inv_q;
  wire wr_src  = reg_we && reg_sel == 3'd0 && !busy;
  wire wr_dst  = reg_we && reg_sel == 3'd1 && !busy;
  wire wr_cnt  = reg_we && reg_sel == 3'd2 && !busy;
  wire wr_mode = reg_we && reg_sel == 3'd3 && !busy;
  wire wr_stat = reg_we && reg_sel == 3'd4;
  wire go      = wr_mode && reg_wdata[0] && !blocked;

  wire [1:0]       n_sz    = reg_wdata[2:1];
  wire [CNT_W-1:0] n_bytes = CNT_W'(1) << n_sz;
  wire cfg_bad = (n_sz == 2'd3) || (cnt_q == '0) ||
                 ((cnt_q & (n_bytes - CNT_W'(1))) != '0) ||
                 (!reg_wdata[5] && !reg_wdata[3] && !reg_wdata[4]);

  wire [CNT_W-1:0]  unit_c   = CNT_W'(1) << sz_q;
  wire [ADDR_W-1:0] unit_a   = ADDR_W'(1) << sz_q;
  wire [CNT_W-1:0]  cnt_next = cnt_q - unit_c;
  wire rd_ok     = st == RD && bus_ack && !bus_err;
  wire wr_ok     = st == WR && bus_ack && !bus_err;
  wire bus_fault = busy && bus_ack && bus_err;

  logic unused_ok;
  assign unused_ok = ^{reg_wdata[ADDR_W-1:12], reg_wdata[7:6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= IDLE;
    else case (st)
      IDLE: if (go && !cfg_bad) st <= RD;
      RD:   if (bus_ack) st <= bus_err ? IDLE : WR;
      WR:   if (bus_ack) begin
              if (bus_err || cnt_next == '0 || steal_q) st <= IDLE;
              else st <= RD;
            end
      default: st <= IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; hold_q <= '0;
      sz_q <= '0; sinc_q <= 1'b0; dinc_q <= 1'b0; steal_q <= 1'b0; ien_q <= '0;
    end else begin
      if (wr_src) src_q <= reg_wdata;
      else if (rd_ok && sinc_q) src_q <= src_q + unit_a;
      if (wr_dst) dst_q <= reg_wdata;
      else if (wr_ok && dinc_q) dst_q <= dst_q + unit_a;
      if (wr_cnt) cnt_q <= reg_wdata[CNT_W-1:0];
      else if (wr_ok) cnt_q <= cnt_next;
      if (rd_ok) hold_q <= bus_rdata;
      if (wr_mode) begin
        sz_q <= reg_wdata[2:1]; sinc_q <= reg_wdata[3]; dinc_q <= reg_wdata[4];
        steal_q <= reg_wdata[5]; ien_q <= reg_wdata[11:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= 1'b0; asc_q <= 1'b0; te_q <= 1'b0; inv_q <= 1'b0;
    end else begin
      if (wr_ok) tc_q <= 1'b1;
      if (wr_ok && cnt_next == '0) asc_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) asc_q <= 1'b0;
      if (bus_fault) te_q <= 1'b1;
      else if (wr_stat && reg_wdata[2]) te_q <= 1'b0;
      if (go && cfg_bad) inv_q <= 1'b1;
      else if (wr_stat && reg_wdata[3]) inv_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      3'd0: reg_rdata = src_q;
      3'd1: reg_rdata = dst_q;
      3'd2: reg_rdata = ADDR_W'(cnt_q);
      3'd3: reg_rdata = ADDR_W'({ien_q, 2'b00, steal_q, dinc_q, sinc_q, sz_q, 1'b0});
      3'd4: reg_rdata = ADDR_W'({busy, inv_q, te_q, asc_q, tc_q});
      default: reg_rdata = '0;
    endcase
  end

  assign bus_req   = busy;
  assign bus_we    = st == WR;
  assign bus_addr  = (st == WR) ? dst_q : src_q;
  assign bus_size  = sz_q;
  assign bus_wdata = hold_q;
  assign irq       = |({inv_q, te_q, asc_q, tc_q} & ien_q);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));
  // R8
  tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> tc_q);
  // R6
  asc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asc_q && !(wr_stat && reg_wdata[1]) |=> asc_q);
  // R10
  block_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && blocked |=> !bus_req);
  // R4
  cnt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok && !wr_cnt |=> $stable(cnt_q));
  // R7
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault |=> !bus_req && te_q);
endmodule

// File: tb/dma_chan_tb.sv
`timescale 1ns/100ps
module dma_chan_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic bus_req, bus_we, bus_ack, bus_err, irq;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0] bus_size;
  int total = 0, bad = 0;
  logic fast = 1'b1, hold = 1'b0, cyc = 1'b0;
  int wr_n = 0, rd_n = 0;
  logic [31:0] wa [0:255];
  logic [31:0] wd [0:255];
  logic [1:0]  wsz [0:255];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction

  function automatic logic [31:0] mk(input int st, sz, si, di, stl, ien);
    return 32'(st) | (32'(sz) << 1) | (32'(si) << 3) | (32'(di) << 4) |
           (32'(stl) << 5) | (32'(ien) << 8);
  endfunction

  assign bus_rdata = pat(bus_addr);
  assign bus_err   = bus_addr[31];
  assign bus_ack   = bus_req && (fast || cyc) && !hold;

  always @(negedge clk) cyc <= ~cyc;
  always @(posedge clk) if (bus_req && bus_ack && !bus_err) begin
    if (bus_we) begin
      wa[wr_n[7:0]] <= bus_addr; wd[wr_n[7:0]] <= bus_wdata; wsz[wr_n[7:0]] <= bus_size;
      wr_n <= wr_n + 1;
    end else rd_n <= rd_n + 1;
  end

  dma_chan dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask
  task automatic ceq(input string tag, input logic [31:0] act, exp);
    chk(act === exp, tag, act, exp);
  endtask
  task automatic wreg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rreg(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; #1 d = reg_rdata;
  endtask
  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      rreg(3'd4, s);
      if (!s[4]) break;
    end
  endtask
  task automatic setup(input logic [31:0] s, d, c);
    wreg(3'd0, s); wreg(3'd1, d); wreg(3'd2, c);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base, rb, unit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 5; s++) begin rreg(3'(s), v); ceq("R1 reset reg", v, 0); end
    ceq("R1 reset irq", {31'b0, irq}, 0);

    setup(32'h1234_5678, 32'h0BAD_F00D, 32'h0000_00C4);
    rreg(3'd0, v); ceq("R2 src rw", v, 32'h1234_5678);
    rreg(3'd1, v); ceq("R2 dst rw", v, 32'h0BAD_F00D);
    rreg(3'd2, v); ceq("R2 cnt rw", v, 32'h0000_00C4);
    wreg(3'd3, 32'h0000_0F3C);
    rreg(3'd3, v); ceq("R2 mode rw", v, 32'h0000_0F3C);
    wreg(3'd3, 32'h0);

    for (int sz = 0; sz < 3; sz++)
      for (int si = 0; si < 2; si++)
        for (int di = 0; di < 2; di++)
          for (int k = 1; k <= 4; k++) begin
            if (si == 0 && di == 0) continue;
            unit = 1 << sz;
            fast = k[0];
            setup(32'h100 + 32'(sz * 64), 32'h2000 + 32'(k * 256), 32'(unit * k));
            base = wr_n; rb = rd_n;
            wreg(3'd3, mk(1, sz, si, di, 0, 0));
            wait_idle();
            ceq("R5 unit count", 32'(wr_n - base), 32'(k));
            ceq("R3 read count", 32'(rd_n - rb), 32'(k));
            for (int i = 0; i < k; i++) begin
              ceq("R4 dst addr", wa[(base + i) % 256], 32'h2000 + 32'(k * 256) + 32'(i * unit * di));
              ceq("R3 wdata", wd[(base + i) % 256], pat(32'h100 + 32'(sz * 64) + 32'(i * unit * si)));
              ceq("R3 size", {30'b0, wsz[(base + i) % 256]}, 32'(sz));
            end
            rreg(3'd0, v); ceq("R4 src end", v, 32'h100 + 32'(sz * 64) + 32'(k * unit * si));
            rreg(3'd1, v); ceq("R4 dst end", v, 32'h2000 + 32'(k * 256) + 32'(k * unit * di));
            rreg(3'd2, v); ceq("R4 cnt end", v, 0);
            rreg(3'd4, v); ceq("R6 R8 status", v, 32'h3);
            wreg(3'd4, 32'h2);
            rreg(3'd4, v); ceq("R6 w1c", v, 32'h1);
          end
    fast = 1'b1;

    wreg(3'd4, 32'h1);
    rreg(3'd4, v); ceq("R8 write no effect", v, 32'h1);
    ceq("R11 irq off", {31'b0, irq}, 0);
    wreg(3'd3, mk(0, 2, 1, 1, 0, 1));
    ceq("R11 irq tc", {31'b0, irq}, 1);
    wreg(3'd3, mk(0, 2, 1, 1, 0, 14));
    ceq("R11 irq masked", {31'b0, irq}, 0);

    hold = 1'b1;
    setup(32'h40, 32'h80, 32'd8);
    wreg(3'd3, mk(1, 2, 1, 1, 0, 0));
    wreg(3'd0, 32'hDEAD);
    wreg(3'd2, 32'h4);
    rreg(3'd0, v); ceq("R2 busy src ignored", v, 32'h40);
    rreg(3'd2, v); ceq("R2 busy cnt ignored", v, 32'd8);
    ceq("R3 req held", {31'b0, bus_req}, 1);
    ceq("R3 held addr", bus_addr, 32'h40);
    hold = 1'b0;
    wait_idle();
    wreg(3'd4, 32'h2);

    base = wr_n;
    setup(32'h300, 32'h400, 32'd8);
    wreg(3'd3, mk(1, 2, 1, 1, 1, 0));
    wait_idle();
    ceq("R5 steal one unit", 32'(wr_n - base), 1);
    rreg(3'd2, v); ceq("R5 steal cnt", v, 32'd4);
    rreg(3'd4, v); ceq("R5 steal no asc", v, 32'h1);
    wreg(3'd3, mk(1, 2, 1, 1, 1, 2));
    wait_idle();
    ceq("R5 steal second", 32'(wr_n - base), 2);
    rreg(3'd4, v); ceq("R6 steal asc", v, 32'h3);
    ceq("R11 irq asc", {31'b0, irq}, 1);
    wreg(3'd4, 32'h0);
    rreg(3'd4, v); ceq("R6 write0 keeps", v, 32'h3);
    rb = rd_n;
    setup(32'h500, 32'h600, 32'd4);
    wreg(3'd3, mk(1, 2, 1, 1, 0, 0));
    wait_idle();
    ceq("R10 asc blocks", 32'(rd_n - rb), 0);
    wreg(3'd4, 32'h2);

    for (int c = 0; c < 4; c++) begin
      rb = rd_n;
      case (c)
        0: begin setup(32'h10, 32'h20, 32'd4); v = mk(1, 3, 1, 1, 0, 0); end
        1: begin setup(32'h10, 32'h20, 32'd0); v = mk(1, 0, 1, 1, 0, 0); end
        2: begin setup(32'h10, 32'h20, 32'd6); v = mk(1, 2, 1, 1, 0, 0); end
        default: begin setup(32'h10, 32'h20, 32'd4); v = mk(1, 0, 0, 0, 0, 0); end
      endcase
      wreg(3'd3, v);
      ceq("R9 no bus", {31'b0, bus_req}, 0);
      rreg(3'd4, v); ceq("R9 inv set", v, 32'h9);
      ceq("R9 no read", 32'(rd_n - rb), 0);
      wreg(3'd4, 32'h0);
      rreg(3'd4, v); ceq("R9 write0 keeps", v, 32'h9);
      if (c == 0) begin
        setup(32'h10, 32'h20, 32'd4);
        wreg(3'd3, mk(1, 2, 1, 1, 0, 0));
        wait_idle();
        ceq("R10 inv blocks", 32'(rd_n - rb), 0);
      end
      wreg(3'd4, 32'h8);
      rreg(3'd4, v); ceq("R9 w1c", v, 32'h1);
    end

    base = wr_n; rb = rd_n;
    setup(32'h8000_0010, 32'h700, 32'd8);
    wreg(3'd3, mk(1, 2, 1, 1, 0, 4));
    wait_idle();
    rreg(3'd4, v); ceq("R7 read fault", v, 32'h5);
    ceq("R7 no traffic", 32'(wr_n - base + rd_n - rb), 0);
    rreg(3'd0, v); ceq("R7 src kept", v, 32'h8000_0010);
    ceq("R11 irq te", {31'b0, irq}, 1);
    wreg(3'd4, 32'h0);
    rreg(3'd4, v); ceq("R7 write0 keeps", v, 32'h5);
    setup(32'h40, 32'h80, 32'd4);
    wreg(3'd3, mk(1, 2, 1, 1, 0, 0));
    wait_idle();
    ceq("R10 te blocks", 32'(rd_n - rb), 0);
    wreg(3'd4, 32'h4);
    rreg(3'd4, v); ceq("R7 w1c", v, 32'h1);
    setup(32'h40, 32'h8000_0000, 32'd8);
    wreg(3'd3, mk(1, 2, 1, 1, 0, 0));
    wait_idle();
    ceq("R7 one read", 32'(rd_n - rb), 1);
    ceq("R7 no write", 32'(wr_n - base), 0);
    rreg(3'd0, v); ceq("R7 src advanced", v, 32'h44);
    rreg(3'd1, v); ceq("R7 dst kept", v, 32'h8000_0000);
    rreg(3'd2, v); ceq("R7 cnt kept", v, 32'd8);
    rreg(3'd4, v); ceq("R7 write fault", v, 32'h5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule